// File: doc/BRIEF.md
# Two-Port Hardware Lock Flag Bank

This block holds eight single-bit ownership flags that two independent ports, left and right, share. A port uses a flag to claim a shared resource on behalf of its software. A claim is atomic, so a flag never has two owners, including when both ports reach for the same free flag in the same clock cycle. The flags sit in their own address space. Each port selects them with a dedicated lock-space enable, which is separate from the enable that port uses for main memory.

Each port carries a 3-bit flag index, a write strobe and one write-data bit. A write of 0 requests the selected flag. A write of 1 releases it. If the other port holds the flag, the request waits inside the bank. Ownership moves to the waiting port on the same edge that the owner's release is taken. While the lock-space enable is high, the read-back bus shows the selected flag as seen from that port: 0 means "this port owns it", and 1 means "free or held by the other side". The same value appears on every bit of the bus. A port with both of its enables low reports standby and makes no access.

Top module: `sem_flag_bank`

## Requirements
- R1: The bank holds eight flags, addressed by a 3-bit index. A write is taken at the rising clock edge only when that port's lock-space enable and write strobe are both high. A write made with the lock-space enable low leaves every flag unchanged.
- R2: A write with data bit 0 to a free flag gives that port ownership at that edge. From then on, the owner reads all-zeros on its read-back bus for that index, and the other port reads all-ones.
- R3: The two ports never both read 0 for the same flag index.
- R4: A request (data 0) for a flag that the other port holds is queued. When the owner writes 1 to that flag, ownership passes to the waiting port at the same edge.
- R5: If both ports request the same free flag at the same edge, the left port becomes owner and the right port's request stays queued.
- R6: A release (data 1) written by a port that does not own the flag has no effect on ownership.
- R7: The standby output of a port is high exactly when both its memory enable and its lock-space enable are low. A port in standby makes no flag access.
- R8: After synchronous reset, every flag is free and unqueued, so both ports read all-ones for all eight indices.
- R9: While a port's lock-space enable is low, its read-back bus is all-ones. Every bit of the read-back bus always carries the same value.
- R10: A repeated request by the current owner, or a release of a free flag, leaves the flag's state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| l_mem_en | input | 1 | Left port main-memory enable; used only for standby |
| l_sem_en | input | 1 | Left port lock-space enable |
| l_wr | input | 1 | Left port write strobe |
| l_idx | input | 3 | Left port flag index |
| l_wdata | input | 1 | Left port write data: 0 = request, 1 = release |
| l_rdata | output | 8 | Left port read-back, same value on every bit |
| l_standby | output | 1 | Left port standby indication |
| r_mem_en | input | 1 | Right port main-memory enable; used only for standby |
| r_sem_en | input | 1 | Right port lock-space enable |
| r_wr | input | 1 | Right port write strobe |
| r_idx | input | 3 | Right port flag index |
| r_wdata | input | 1 | Right port write data: 0 = request, 1 = release |
| r_rdata | output | 8 | Right port read-back, same value on every bit |
| r_standby | output | 1 | Right port standby indication |

## Verification
The hardest case to reach from the ports is a queued request that is handed over at the same edge as a new contention on the same flag. This needs a prior tie or a blocked request, followed by the owner's release on exactly the flag the other side is waiting for. Random index choices over eight flags seldom line up like that. The directed sequences therefore build the tie, the queue and the handoff explicitly. The random phase then narrows indices to two flags, so that contention, queued requests and releases by non-owners come up often. After every operation, both ports' views of all eight flags are swept and compared with the bench model.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        logic req;
        logic rel;
    } flag_op_t;

    // Value a port sees for a flag: 0 only when that port is the owner.
    function automatic logic port_view(owner_e own, logic is_left);
        return is_left ? (own != OWN_LEFT) : (own != OWN_RIGHT);
    endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode
    import sem_bank_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mem_en,
    input  logic                 sem_en,
    input  logic                 wr,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wdata,
    output logic [NUM_FLAGS-1:0] req_vec,
    output logic [NUM_FLAGS-1:0] rel_vec,
    output logic                 standby
);

    logic     active;
    flag_op_t op;

    assign active  = sem_en && wr;
    assign op.req  = active && !wdata;
    assign op.rel  = active && wdata;
    assign standby = !mem_en && !sem_en;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_sel
        assign req_vec[g] = op.req && (idx == IDX_W'(g));
        assign rel_vec[g] = op.rel && (idx == IDX_W'(g));
    end

    // R7: a port in standby issues nothing to any flag
    p_standby_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        standby |-> (req_vec == '0 && rel_vec == '0));

    // R1: at most one flag is addressed per port per cycle
    p_single_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_vec | rel_vec));

endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
    import sem_bank_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   l_req,
    input  logic   l_rel,
    input  logic   r_req,
    input  logic   r_rel,
    output owner_e owner
);

    owner_e own_q, own_d;
    logic   wait_l_q, wait_l_d;
    logic   wait_r_q, wait_r_d;

    always_comb begin
        own_d    = own_q;
        wait_l_d = wait_l_q;
        wait_r_d = wait_r_q;
        unique case (own_q)
            OWN_NONE: begin
                if (l_req) begin
                    own_d    = OWN_LEFT;
                    wait_l_d = 1'b0;
                    wait_r_d = r_req;
                end else if (r_req) begin
                    own_d    = OWN_RIGHT;
                    wait_l_d = 1'b0;
                    wait_r_d = 1'b0;
                end
            end
            OWN_LEFT: begin
                if (l_rel) begin
                    own_d    = (wait_r_q || r_req) ? OWN_RIGHT : OWN_NONE;
                    wait_r_d = 1'b0;
                end else if (r_req) begin
                    wait_r_d = 1'b1;
                end
            end
            OWN_RIGHT: begin
                if (r_rel) begin
                    own_d    = (wait_l_q || l_req) ? OWN_LEFT : OWN_NONE;
                    wait_l_d = 1'b0;
                end else if (l_req) begin
                    wait_l_d = 1'b1;
                end
            end
            default: begin
                own_d    = OWN_NONE;
                wait_l_d = 1'b0;
                wait_r_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_q    <= OWN_NONE;
            wait_l_q <= 1'b0;
            wait_r_q <= 1'b0;
        end else begin
            own_q    <= own_d;
            wait_l_q <= wait_l_d;
            wait_r_q <= wait_r_d;
        end
    end

    assign owner = own_q;

    // R5: a tie on a free flag goes to the left, the right stays queued
    p_tie_left_r5: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_NONE && l_req && r_req) |=> (own_q == OWN_LEFT && wait_r_q));

    // R4: the owner's release hands a queued flag to the waiting side
    p_handoff_r4: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_LEFT && l_rel && wait_r_q) |=> own_q == OWN_RIGHT);

    // R6: a release from the non-owner leaves ownership alone
    p_foreign_release_r6: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_RIGHT && l_rel && !r_rel) |=> own_q == OWN_RIGHT);

    // R10: the owner requesting again changes nothing
    p_owner_rerequest_r10: assert property (@(posedge clk) disable iff (rst)
        (own_q == OWN_LEFT && l_req && !r_req) |=> (own_q == OWN_LEFT && $stable(wait_r_q)));

    // R8: the cycle after reset the flag is free and unqueued
    p_reset_free_r8: assert property (@(posedge clk)
        $past(rst) |-> (own_q == OWN_NONE && !wait_l_q && !wait_r_q));

endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux
    import sem_bank_pkg::*;
#(
    parameter int   NUM_FLAGS = 8,
    parameter int   IDX_W     = $clog2(NUM_FLAGS),
    parameter int   DATA_W    = 8,
    parameter logic IS_LEFT   = 1'b1
) (
    input  logic [NUM_FLAGS-1:0][1:0] owners,
    input  logic                      sem_en,
    input  logic [IDX_W-1:0]          idx,
    output logic [DATA_W-1:0]         rdata
);

    logic seen;

    always_comb begin
        seen = port_view(owner_e'(owners[idx]), IS_LEFT);
        rdata = sem_en ? {DATA_W{seen}} : {DATA_W{1'b1}};
    end

    // R9: every bit of the read-back bus carries the same value
    always_comb begin
        p_uniform_bits_r9: assert ((rdata == '0) || (rdata == '1));
    end

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
    import sem_bank_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_mem_en,
    input  logic              l_sem_en,
    input  logic              l_wr,
    input  logic [IDX_W-1:0]  l_idx,
    input  logic              l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    output logic              l_standby,
    input  logic              r_mem_en,
    input  logic              r_sem_en,
    input  logic              r_wr,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic              r_wdata,
    output logic [DATA_W-1:0] r_rdata,
    output logic              r_standby
);

    logic [NUM_FLAGS-1:0]      l_req, l_rel, r_req, r_rel;
    logic [NUM_FLAGS-1:0][1:0] owners;

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_l (
        .clk(clk), .rst(rst), .mem_en(l_mem_en), .sem_en(l_sem_en), .wr(l_wr),
        .idx(l_idx), .wdata(l_wdata), .req_vec(l_req), .rel_vec(l_rel),
        .standby(l_standby)
    );

    sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_dec_r (
        .clk(clk), .rst(rst), .mem_en(r_mem_en), .sem_en(r_sem_en), .wr(r_wr),
        .idx(r_idx), .wdata(r_wdata), .req_vec(r_req), .rel_vec(r_rel),
        .standby(r_standby)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        owner_e own;
        sem_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .l_req(l_req[g]), .l_rel(l_rel[g]),
            .r_req(r_req[g]), .r_rel(r_rel[g]),
            .owner(own)
        );
        assign owners[g] = own;
    end

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W), .IS_LEFT(1'b1)) u_rd_l (
        .owners(owners), .sem_en(l_sem_en), .idx(l_idx), .rdata(l_rdata)
    );

    sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W), .DATA_W(DATA_W), .IS_LEFT(1'b0)) u_rd_r (
        .owners(owners), .sem_en(r_sem_en), .idx(r_idx), .rdata(r_rdata)
    );

    // R3: both ports never see ownership of the same flag
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(l_sem_en && r_sem_en && l_idx == r_idx && l_rdata == '0 && r_rdata == '0));

    // R1: a write with the lock-space enable low leaves the flags unchanged
    p_gated_write_r1: assert property (@(posedge clk) disable iff (rst)
        (!l_sem_en && !r_sem_en) |=> $stable(owners));

endmodule

// File: tb/test_sem_flag_bank.sv
`timescale 1ns/1ps
module test_sem_flag_bank;

    localparam int NF = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          l_mem_en, l_sem_en, l_wr, l_wdata, l_standby;
    logic          r_mem_en, r_sem_en, r_wr, r_wdata, r_standby;
    logic [2:0]    l_idx, r_idx;
    logic [DW-1:0] l_rdata, r_rdata;

    int total = 0;
    int bad   = 0;
    int own_m [NF];   // 0 free, 1 left, 2 right
    bit wl_m  [NF];
    bit wr_m  [NF];

    always #2.5 clk = ~clk;

    sem_flag_bank #(.NUM_FLAGS(NF), .DATA_W(DW)) i_sem_flag_bank (
        .clk(clk), .rst(rst),
        .l_mem_en(l_mem_en), .l_sem_en(l_sem_en), .l_wr(l_wr), .l_idx(l_idx),
        .l_wdata(l_wdata), .l_rdata(l_rdata), .l_standby(l_standby),
        .r_mem_en(r_mem_en), .r_sem_en(r_sem_en), .r_wr(r_wr), .r_idx(r_idx),
        .r_wdata(r_wdata), .r_rdata(r_rdata), .r_standby(r_standby)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] view_exp(int i, bit left);
        if (left) return (own_m[i] == 1) ? '0 : '1;
        return (own_m[i] == 2) ? '0 : '1;
    endfunction

    function automatic void model_step(bit ls, bit lw, int li, bit ld,
                                       bit rs, bit rw, int ri, bit rd);
        for (int i = 0; i < NF; i++) begin
            bit lq = ls && lw && li == i && !ld;
            bit lr = ls && lw && li == i && ld;
            bit rq = rs && rw && ri == i && !rd;
            bit rr = rs && rw && ri == i && rd;
            case (own_m[i])
                0: if (lq) begin own_m[i] = 1; wl_m[i] = 0; wr_m[i] = rq; end
                   else if (rq) begin own_m[i] = 2; wl_m[i] = 0; wr_m[i] = 0; end
                1: if (lr) begin own_m[i] = (wr_m[i] || rq) ? 2 : 0; wr_m[i] = 0; end
                   else if (rq) wr_m[i] = 1;
                default: if (rr) begin own_m[i] = (wl_m[i] || lq) ? 1 : 0; wl_m[i] = 0; end
                   else if (lq) wl_m[i] = 1;
            endcase
        end
    endfunction

    task automatic op(bit lm, bit ls, bit lw, int li, bit ld,
                      bit rm, bit rs, bit rw, int ri, bit rd, string req);
        @(negedge clk);
        l_mem_en = lm; l_sem_en = ls; l_wr = lw; l_idx = 3'(li); l_wdata = ld;
        r_mem_en = rm; r_sem_en = rs; r_wr = rw; r_idx = 3'(ri); r_wdata = rd;
        #0.5;
        chk("R7", {7'b0, l_standby}, {7'b0, (!lm && !ls)});
        chk("R7", {7'b0, r_standby}, {7'b0, (!rm && !rs)});
        @(posedge clk);
        model_step(ls, lw, li, ld, rs, rw, ri, rd);
        #0.5;
        l_wr = 0; r_wr = 0; l_sem_en = 1; r_sem_en = 1;
        for (int i = 0; i < NF; i++) begin
            l_idx = 3'(i); r_idx = 3'(i);
            #0.2;
            chk(req, l_rdata, view_exp(i, 1));
            chk(req, r_rdata, view_exp(i, 0));
            chk("R3", {7'b0, (l_rdata == '0 && r_rdata == '0)}, 8'h00);
        end
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < NF; i++) begin own_m[i] = 0; wl_m[i] = 0; wr_m[i] = 0; end
        rst = 1;
        {l_mem_en, l_sem_en, l_wr, l_wdata, r_mem_en, r_sem_en, r_wr, r_wdata} = '0;
        l_idx = 0; r_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R8: reset state, sweep all flags on both ports
        l_sem_en = 1; r_sem_en = 1;
        for (int i = 0; i < NF; i++) begin
            l_idx = 3'(i); r_idx = 3'(i); #0.2;
            chk("R8", l_rdata, '1); chk("R8", r_rdata, '1);
        end
        // R2: left claims flag 3
        op(0,1,1,3,0, 0,0,0,0,0, "R2");
        // R9: lock-space enable low reads all-ones even for owner
        @(negedge clk); l_sem_en = 0; l_idx = 3; #0.2;
        chk("R9", l_rdata, '1);
        // R1: write with lock-space enable low ignored
        op(1,0,1,3,1, 1,0,1,5,0, "R1");
        // R10: owner re-request, release of free flag
        op(0,1,1,3,0, 0,1,1,6,1, "R10");
        // R4: right queues on 3, left releases, handoff
        op(0,0,0,0,0, 0,1,1,3,0, "R4");
        op(0,1,1,3,1, 0,0,0,0,0, "R4");
        // R6: left (non-owner) releases 3, ignored
        op(0,1,1,3,1, 0,0,0,0,0, "R6");
        // R5: tie on free flag 5
        op(0,1,1,5,0, 0,1,1,5,0, "R5");
        op(0,1,1,5,1, 0,0,0,0,0, "R5");
        // R7: standby with no access
        op(0,0,1,2,0, 0,0,1,2,0, "R7");
        // random phase, indices narrowed to two flags
        for (int n = 0; n < 400; n++) begin
            op($urandom_range(1), $urandom_range(3) != 0, $urandom_range(1),
               $urandom_range(1), $urandom_range(1),
               $urandom_range(1), $urandom_range(3) != 0, $urandom_range(1),
               $urandom_range(1), $urandom_range(1), "R4");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule